// File: doc/BRIEF.md
# Ethernet Address Hash Filter

This block decides whether a received individual destination address passes a 64-bit hash filter. The six address bytes arrive one per accepted cycle on a byte stream, qualified by a valid flag and marked at the end by a last flag. While the bytes stream in, the block runs a reflected CRC-32 over them. The six most significant bits of the final CRC value form a hash index, and that index selects one bit of a 64-entry table.

The table is held in two 32-bit registers, a lower one and an upper one, which a host writes whole. Software sets table bits for several addresses by OR-ing them into the register images before writing, so the registers come up empty and are then loaded with the union. One cycle after the sixth byte is accepted, the block pulses a result strobe. With the strobe it gives the selected table bit and the hash index, so a software model of the hash can be checked against the hardware. If the stream ends before six bytes, the block reports an aborted result that never matches.

Top module: `hash_filter`

## Requirements
- R1: After reset the result strobe and abort flag are low, and both table registers are zero, so any complete address reports no hit.
- R2: The hash index equals bits 31:26 of a CRC-32 that is preset to 0xFFFFFFFF, takes each byte least-significant bit first (when data bit XOR CRC bit 0 is 1, shift right and XOR 0xEDB88320, otherwise only shift right), covers exactly six bytes with the first byte on the stream first, and is not inverted at the end.
- R3: An index of 32 to 63 selects bit (index − 32) of the upper table register. An index of 0 to 31 selects bit index of the lower table register. No other bit affects the hit.
- R4: A host write with tblWrEn high replaces the whole register picked by tblWrSel (1 = upper, 0 = lower) at the next clock edge. Results that finish on a later edge use the new value.
- R5: resultValid is high for exactly one cycle, the cycle after the sixth byte is accepted. In that cycle resultHit equals the selected table bit and resultAbort is 0.
- R6: Cycles with byteValid low are ignored, so idle gaps between address bytes do not change the hash.
- R7: If byteLast is high on an accepted byte that is first through fifth, the next cycle shows resultValid 1, resultHit 0, resultAbort 1 and hashIndex 0. The following byte starts a new address.
- R8: The byte accepted on the cycle after the sixth byte starts a new address. Back-to-back addresses each produce their own result.
- R9: byteLast high on the sixth byte is a normal completion (resultAbort 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byteValid | input | 1 | Address byte present this cycle |
| byteData | input | 8 | Address byte |
| byteLast | input | 1 | Final byte of the stream |
| tblWrEn | input | 1 | Host table register write strobe |
| tblWrSel | input | 1 | Register select: 1 upper, 0 lower |
| tblWrData | input | 32 | Value written to the selected register |
| resultValid | output | 1 | One-cycle result strobe |
| resultHit | output | 1 | Selected table bit (0 on abort) |
| resultAbort | output | 1 | Stream ended before six bytes |
| hashIndex | output | 6 | Hash index of the completed address |

## Verification
A CRC register that is wrong in any bit spreads to other bits within the following bytes. It shows up as a wrong hashIndex on the strobe cycle of that same address, which is at most six accepted bytes later. A byte counter that is off by one moves the strobe a cycle early or late, or produces a false abort, and this is visible on the very next result. A table register fault or a swapped register select turns up as a wrong resultHit. It is exposed by filling the other register with ones and clearing the target bit.

// File: rtl/hash_filter_pkg.sv
package hash_filter_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic seed;    // use preset value instead of running CRC
    logic step;    // fold byteData into the CRC
    logic finish;  // last address byte: capture result
    logic abort;   // stream ended early: capture abort result
  } hf_ctl_t;

  // Eight reflected CRC steps, data taken LSB first
  function automatic logic [31:0] crcByte(input logic [31:0] crcIn,
                                          input logic [7:0]  dataIn,
                                          input logic [31:0] poly);
    logic [31:0] c;
    c = crcIn;
    for (int k = 0; k < 8; k++) begin
      if (dataIn[k] ^ c[0]) c = (c >> 1) ^ poly;
      else                  c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/hf_control.sv
module hf_control
  import hash_filter_pkg::*;
#(
  parameter int ADDR_BYTES = 6
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    byteValid,
  input  logic    byteLast,
  output hf_ctl_t ctl
);
  localparam int CW = $clog2(ADDR_BYTES + 1);
  localparam logic [CW-1:0] LAST_IDX = CW'(ADDR_BYTES - 1);

  logic [CW-1:0] byteCnt;

  always_comb begin
    ctl.seed   = byteValid && (byteCnt == '0);
    ctl.step   = byteValid;
    ctl.finish = byteValid && (byteCnt == LAST_IDX);
    ctl.abort  = byteValid && byteLast && (byteCnt != LAST_IDX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       byteCnt <= '0;
    else if (ctl.finish || ctl.abort) byteCnt <= '0;
    else if (byteValid)               byteCnt <= byteCnt + 1'b1;
  end

  // R5: the counter never runs past the last address byte
  p_cnt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    byteCnt <= LAST_IDX);

  // R7: completion and abort never coincide
  p_finish_abort_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl.finish, ctl.abort}));

  // R8: after the sixth byte the next byte is a first byte
  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.finish |=> (byteCnt == '0));

  // R6: an idle cycle leaves the position unchanged
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !byteValid |=> $stable(byteCnt));

endmodule

// File: rtl/hf_table.sv
module hf_table #(
  parameter int REG_W = 32,
  parameter int BANKS = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wrEn,
  input  logic [$clog2(BANKS)-1:0] wrSel,
  input  logic [REG_W-1:0]       wrData,
  output logic [BANKS*REG_W-1:0] tableBits
);
  logic [REG_W-1:0] bankReg [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          bankReg[b] <= '0;
      else if (wrEn && (int'(wrSel) == b)) bankReg[b] <= wrData;
    end
    assign tableBits[b*REG_W +: REG_W] = bankReg[b];
  end

  // R4: a write lands whole in the selected register
  p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |=> (tableBits[$past(wrSel)*REG_W +: REG_W] == $past(wrData)));

endmodule

// File: rtl/hf_datapath.sv
module hf_datapath
  import hash_filter_pkg::*;
#(
  parameter int          CRC_W  = 32,
  parameter logic [31:0] POLY   = 32'hEDB88320,
  parameter logic [31:0] PRESET = 32'hFFFFFFFF,
  parameter int          TBL_W  = 64,
  parameter int          IDX_W  = $clog2(TBL_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  hf_ctl_t          ctl,
  input  logic [7:0]       byteData,
  input  logic [TBL_W-1:0] tableBits,
  output logic             resultValid,
  output logic             resultHit,
  output logic             resultAbort,
  output logic [IDX_W-1:0] hashIndex
);
  logic [CRC_W-1:0] crcReg;
  logic [CRC_W-1:0] crcBase;
  logic [CRC_W-1:0] crcNext;
  logic [IDX_W-1:0] idxNext;

  always_comb begin
    crcBase = ctl.seed ? PRESET : crcReg;
    crcNext = crcByte(crcBase, byteData, POLY);
    idxNext = crcNext[CRC_W-1 -: IDX_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        crcReg <= PRESET;
    else if (ctl.step) crcReg <= crcNext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resultValid <= 1'b0;
      resultHit   <= 1'b0;
      resultAbort <= 1'b0;
      hashIndex   <= '0;
    end else begin
      resultValid <= ctl.finish || ctl.abort;
      if (ctl.finish) begin
        resultHit   <= tableBits[idxNext];
        resultAbort <= 1'b0;
        hashIndex   <= idxNext;
      end else if (ctl.abort) begin
        resultHit   <= 1'b0;
        resultAbort <= 1'b1;
        hashIndex   <= '0;
      end
    end
  end

  // R5: a result strobe only follows a completion or an abort strobe
  p_valid_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    resultValid |-> $past(ctl.finish || ctl.abort));

  // R9: a completed address is never reported as aborted
  p_finish_not_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.finish |=> (resultValid && !resultAbort));

  // R7: an aborted result never hits
  p_abort_no_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.abort |=> (resultValid && resultAbort && !resultHit));

endmodule

// File: rtl/hash_filter.sv
module hash_filter
  import hash_filter_pkg::*;
#(
  parameter int REG_W      = 32,
  parameter int ADDR_BYTES = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        byteValid,
  input  logic [7:0]  byteData,
  input  logic        byteLast,
  input  logic        tblWrEn,
  input  logic        tblWrSel,
  input  logic [31:0] tblWrData,
  output logic        resultValid,
  output logic        resultHit,
  output logic        resultAbort,
  output logic [5:0]  hashIndex
);
  localparam int BANKS = 2;
  localparam int TBL_W = BANKS * REG_W;

  hf_ctl_t          ctl;
  logic [TBL_W-1:0] tableBits;

  hf_control #(.ADDR_BYTES(ADDR_BYTES)) u_control (
    .clk      (clk),
    .rst_n    (rst_n),
    .byteValid(byteValid),
    .byteLast (byteLast),
    .ctl      (ctl)
  );

  hf_table #(.REG_W(REG_W), .BANKS(BANKS)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wrEn     (tblWrEn),
    .wrSel    (tblWrSel),
    .wrData   (tblWrData),
    .tableBits(tableBits)
  );

  hf_datapath #(.TBL_W(TBL_W)) u_datapath (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl        (ctl),
    .byteData   (byteData),
    .tableBits  (tableBits),
    .resultValid(resultValid),
    .resultHit  (resultHit),
    .resultAbort(resultAbort),
    .hashIndex  (hashIndex)
  );

endmodule

// File: tb/test_hash_filter.sv
module test_hash_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = '0;
  logic        byteLast = 1'b0;
  logic        tblWrEn = 1'b0;
  logic        tblWrSel = 1'b0;
  logic [31:0] tblWrData = '0;
  logic        resultValid, resultHit, resultAbort;
  logic [5:0]  hashIndex;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hash_filter i_hash_filter (
    .clk(clk), .rst_n(rst_n), .byteValid(byteValid), .byteData(byteData),
    .byteLast(byteLast), .tblWrEn(tblWrEn), .tblWrSel(tblWrSel),
    .tblWrData(tblWrData), .resultValid(resultValid), .resultHit(resultHit),
    .resultAbort(resultAbort), .hashIndex(hashIndex)
  );

  localparam int NV = 6;
  localparam logic [47:0] VEC_ADDR [NV] = '{
    48'h0000_0000_0000, 48'hFFFF_FFFF_FFFF, 48'h0004_9F12_3456,
    48'h0102_0304_0506, 48'hA5C3_5A3C_0F81, 48'h0011_2233_4455 };
  localparam bit VEC_HIT [NV] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};

  function automatic logic [5:0] refHash(input logic [47:0] a);
    logic [31:0] c;
    logic [7:0]  b;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < 6; i++) begin
      b = a[47-8*i -: 8];
      for (int j = 0; j < 8; j++) begin
        c = ((b[0] ^ c[0]) != 1'b0) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        b = b >> 1;
      end
    end
    return c[31:26];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeReg(input bit sel, input logic [31:0] val);
    @(negedge clk);
    tblWrEn = 1'b1; tblWrSel = sel; tblWrData = val;
    @(negedge clk);
    tblWrEn = 1'b0;
  endtask

  // Load a table image: everything in the bank set to fill, target bit set to bitVal
  task automatic loadFor(input logic [5:0] idx, input bit bitVal, input logic [31:0] fill);
    logic [31:0] hiV, loV;
    hiV = fill; loV = fill;
    if (idx >= 6'd32) hiV[idx-6'd32] = bitVal;
    else              loV[idx[4:0]] = bitVal;
    writeReg(1'b1, hiV);
    writeReg(1'b0, loV);
  endtask

  // Drive six bytes, gap idle cycles between them; end at the negedge after the last edge
  task automatic sendAddr(input logic [47:0] a, input int gap, input bit lastOn6);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      byteValid = 1'b1; byteData = a[47-8*i -: 8];
      byteLast = lastOn6 && (i == 5);
      if (gap > 0 && i < 5) begin
        @(negedge clk);
        byteValid = 1'b0; byteLast = 1'b0;
        repeat (gap - 1) @(negedge clk);
      end
    end
    @(negedge clk);
    byteValid = 1'b0; byteLast = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [5:0] h;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 valid after reset", resultValid, 0);
    chk("R1 abort after reset", resultAbort, 0);
    sendAddr(48'h0004_9F12_3456, 0, 1'b0);
    chk("R1 empty table no hit", resultHit, 0);
    chk("R5 valid after sixth byte", resultValid, 1);
    @(negedge clk);
    chk("R5 valid is one cycle", resultValid, 0);

    // Vector table: R2 index, R3 bank select, R5 hit
    for (int v = 0; v < NV; v++) begin
      h = refHash(VEC_ADDR[v]);
      loadFor(h, VEC_HIT[v], VEC_HIT[v] ? 32'h0 : 32'hFFFF_FFFF);
      sendAddr(VEC_ADDR[v], 0, 1'b0);
      chk("R2 hash index", hashIndex, h);
      chk("R3 selected bit hit", resultHit, VEC_HIT[v]);
      chk("R5 strobe", resultValid, 1);
      chk("R9 not aborted", resultAbort, 0);
    end

    // R3: only the target bit matters; the other bank full of ones
    h = refHash(48'h0102_0304_0506);
    if (h >= 6'd32) begin writeReg(1'b1, 32'h0); writeReg(1'b0, 32'hFFFF_FFFF); end
    else            begin writeReg(1'b0, 32'h0); writeReg(1'b1, 32'hFFFF_FFFF); end
    sendAddr(48'h0102_0304_0506, 0, 1'b0);
    chk("R3 other bank ignored", resultHit, 0);

    // R4: whole-register replacement takes effect
    loadFor(h, 1'b1, 32'h0);
    sendAddr(48'h0102_0304_0506, 0, 1'b0);
    chk("R4 written bit hits", resultHit, 1);
    writeReg(h >= 6'd32, 32'h0);
    sendAddr(48'h0102_0304_0506, 0, 1'b0);
    chk("R4 overwrite clears hit", resultHit, 0);

    // R6: idle gaps
    h = refHash(48'hA5C3_5A3C_0F81);
    loadFor(h, 1'b1, 32'h0);
    sendAddr(48'hA5C3_5A3C_0F81, 3, 1'b0);
    chk("R6 gap hash index", hashIndex, h);
    chk("R6 gap hit", resultHit, 1);

    // R9: last on sixth byte completes normally
    sendAddr(48'hA5C3_5A3C_0F81, 0, 1'b1);
    chk("R9 last on sixth abort", resultAbort, 0);
    chk("R9 last on sixth hit", resultHit, 1);

    // R7: early last aborts
    writeReg(1'b0, 32'hFFFF_FFFF); writeReg(1'b1, 32'hFFFF_FFFF);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      byteValid = 1'b1; byteData = 8'h11 * i[7:0]; byteLast = (i == 2);
    end
    @(negedge clk);
    byteValid = 1'b0; byteLast = 1'b0;
    chk("R7 abort valid", resultValid, 1);
    chk("R7 abort flag", resultAbort, 1);
    chk("R7 abort no hit", resultHit, 0);
    chk("R7 abort index", hashIndex, 0);
    h = refHash(48'h0011_2233_4455);
    loadFor(h, 1'b1, 32'h0);
    sendAddr(48'h0011_2233_4455, 0, 1'b0);
    chk("R7 restart index", hashIndex, h);
    chk("R7 restart hit", resultHit, 1);

    // R8: back-to-back addresses
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (i == 6) begin
        chk("R8 first result valid", resultValid, 1);
        chk("R8 first index", hashIndex, refHash(48'h0011_2233_4455));
        chk("R8 first hit", resultHit, 1);
      end
      byteValid = 1'b1;
      byteData = (i < 6) ? 8'(48'h0011_2233_4455 >> (40 - 8*i))
                         : 8'(48'h0102_0304_0506 >> (40 - 8*(i-6)));
    end
    @(negedge clk);
    byteValid = 1'b0;
    chk("R8 second result valid", resultValid, 1);
    chk("R8 second index", hashIndex, refHash(48'h0102_0304_0506));
    chk("R8 second abort", resultAbort, 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule